// File: doc/BRIEF.md
# Double-Data-Rate Output Stage with Registered Enable

This block serialises two single-rate bits per clock period into one double-data-rate stream on an output pin. In every period it takes an "early" bit and a "late" bit. The early bit drives the pin while the clock is high. The late bit drives it while the clock is low. A registered output enable sits beside the data path. When that enable is low, the pad driver next to this block leaves the pin at high impedance for the whole period.

Two storage elements feed the output. The late bit is captured by a flop on the rising edge. The early bit is held by a stage that is transparent while the clock is low and holds while it is high. A multiplexer selects between the two by the clock level. It always passes the element that is not changing in the current half-period, so the pin moves only just after a clock edge. The `LANES` parameter replicates the data path for narrow buses. All lanes share one enable.

Top module: `ddrx_out`

## Requirements
- R1: On each rising edge the stage captures `d_late`. Starting at the falling edge that follows, that value drives `pad_dat` for the whole low phase.
- R2: The early stage follows `d_early` while `clk` is low and holds it while `clk` is high. The value present at a rising edge drives `pad_dat` for the high phase that begins at that edge.
- R3: Within each clock period, starting at a rising edge, `pad_dat` shows the early bit during the high phase and then the late bit during the low phase. Both bits are the ones presented before that rising edge.
- R4: `pad_en` is `oe_in` registered on the rising edge. It therefore stays constant for a whole period. A value of 1 means drive the pin and a value of 0 means high impedance.
- R5: While `rst` is high at a rising edge, the late stage and the enable register clear. While `rst` is high with `clk` low, the early stage clears. After a reset edge, `pad_en` is 0 and `pad_dat` is 0 in both phases, whatever the data inputs hold.
- R6: Lanes are independent. Bit i of `pad_dat` carries only bit i of `d_early` and bit i of `d_late`.
- R7: No combinational path runs from the data inputs to `pad_dat`. When the inputs change during the low phase, the pin does not change until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output clock; its level selects the phase |
| rst | input | 1 | Synchronous active-high reset |
| d_early | input | LANES | Bit sent in the high phase of the next period |
| d_late | input | LANES | Bit sent in the low phase of the next period |
| oe_in | input | 1 | Output enable request, registered on the rising edge |
| pad_dat | output | LANES | Double-rate data to the pad driver |
| pad_en | output | 1 | Registered pad drive enable (0 = high impedance) |

## Verification
The phase properties assume that the data inputs, the enable and the reset change only inside the low phase. They also assume these inputs stay stable through the following rising edge and the whole high phase after it. Under that assumption, sampling the early bit at the falling edge is valid, and so is sampling the late bit at the rising edge. The stimulus meets the assumption by updating every input a quarter period after each falling edge. It then samples the pin in the middle of each half-period. Several checks also change the data inputs mid low phase and confirm that the pin does not move.

// File: rtl/ddrx_pkg.sv
`timescale 1ns/1ps
package ddrx_pkg;

    // Clock level read as the output phase selector.
    typedef enum logic {
        PHASE_LOW  = 1'b0,
        PHASE_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/ddrx_rise_stage.sv
`timescale 1ns/1ps
module ddrx_rise_stage #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_late,
    input  logic         oe_in,
    output logic [W-1:0] late_q,
    output logic         en_q
);

    typedef struct packed {
        logic [W-1:0] late;
        logic         en;
    } rise_st_t;

    rise_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.late = '0;
            st_d.en   = 1'b0;
        end else begin
            st_d.late = d_late;
            st_d.en   = oe_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign late_q = st_q.late;
    assign en_q   = st_q.en;

    AST_LATE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (late_q == $past(d_late))); // R1
    AST_EN_REGISTERED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (en_q == $past(oe_in))); // R4

endmodule

// File: rtl/ddrx_low_hold.sv
`timescale 1ns/1ps
module ddrx_low_hold #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_early,
    output logic [W-1:0] early_q
);

    logic [W-1:0] early_d;

    always_comb begin
        early_d = rst ? '0 : d_early;
    end

    // Transparent while the clock is low, closed while it is high.
    always_latch begin
        if (!clk) begin
            early_q <= early_d;
        end
    end

    // Inputs are held through the high phase, so the closed stage still matches them.
    AST_EARLY_HELD: assert property (@(negedge clk) disable iff (rst)
        early_q == d_early); // R2

endmodule

// File: rtl/ddrx_phase_sel.sv
`timescale 1ns/1ps
module ddrx_phase_sel #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] early_q,
    input  logic [W-1:0] late_q,
    output logic [W-1:0] pad_dat
);
    import ddrx_pkg::*;

    for (genvar g = 0; g < W; g++) begin : g_lane
        logic bit_d;
        always_comb begin
            unique case (phase_e'(clk))
                PHASE_HIGH: bit_d = early_q[g];
                PHASE_LOW:  bit_d = late_q[g];
                default:    bit_d = late_q[g];
            endcase
        end
        assign pad_dat[g] = bit_d;
    end

endmodule

// File: rtl/ddrx_out.sv
`timescale 1ns/1ps
module ddrx_out #(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] d_early,
    input  logic [LANES-1:0] d_late,
    input  logic             oe_in,
    output logic [LANES-1:0] pad_dat,
    output logic             pad_en
);

    localparam int W = LANES;

    logic [W-1:0] late_q;
    logic [W-1:0] early_q;
    logic         en_q;

    ddrx_rise_stage #(.W(W)) rise_i (
        .clk    (clk),
        .rst    (rst),
        .d_late (d_late),
        .oe_in  (oe_in),
        .late_q (late_q),
        .en_q   (en_q)
    );

    ddrx_low_hold #(.W(W)) hold_i (
        .clk     (clk),
        .rst     (rst),
        .d_early (d_early),
        .early_q (early_q)
    );

    ddrx_phase_sel #(.W(W)) sel_i (
        .clk     (clk),
        .early_q (early_q),
        .late_q  (late_q),
        .pad_dat (pad_dat)
    );

    assign pad_en = en_q;

    // Just before a rising edge the pin is in its low phase and carries the late bit.
    AST_LOW_PHASE_LATE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pad_dat == $past(d_late))); // R3
    // Just before a falling edge the pin is in its high phase and carries the early bit.
    AST_HIGH_PHASE_EARLY: assert property (@(negedge clk) disable iff (rst)
        pad_dat == d_early); // R3
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!pad_en && pad_dat == '0)); // R5

endmodule

// File: tb/ddrx_out_tb.sv
`timescale 1ns/1ps
module ddrx_out_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int QTR        = CLK_PERIOD / 4;
    localparam int LANES      = 2;
    localparam int WATCHDOG   = 5000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] d_early = '0;
    logic [LANES-1:0] d_late  = '0;
    logic             oe_in   = 1'b0;
    logic [LANES-1:0] pad_dat;
    logic             pad_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddrx_out #(.LANES(LANES)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .d_early (d_early),
        .d_late  (d_late),
        .oe_in   (oe_in),
        .pad_dat (pad_dat),
        .pad_en  (pad_en)
    );

    task automatic chk(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_en(input string req, input logic exp);
        n_checks++;
        if (pad_en !== exp) begin
            n_fails++;
            $display("FAIL %s: actual pad_en %b expected %b at %0t", req, pad_en, exp, $time);
        end
    endtask

    // Called a quarter period after a falling edge. It drives one pair, then checks both
    // phases of the period that begins at the next rising edge, and returns in the low phase.
    task automatic send_pair(input logic [LANES-1:0] e, input logic [LANES-1:0] l,
                             input logic oe, input string req);
        d_early = e;
        d_late  = l;
        oe_in   = oe;
        @(posedge clk);
        #(QTR);
        chk_en({req, " en-high"}, oe);
        if (oe) chk({req, " early in high phase"}, pad_dat, e);
        #(2*QTR);
        chk_en({req, " en-low"}, oe);
        if (oe) chk({req, " late in low phase"}, pad_dat, l);
    endtask

    task automatic test_reset();
        d_early = '1;
        d_late  = '1;
        oe_in   = 1'b1;
        repeat (3) @(posedge clk);
        #(QTR);
        chk_en("R5 reset en high phase", 1'b0);
        chk("R5 reset data high phase", pad_dat, '0);
        #(2*QTR);
        chk_en("R5 reset en low phase", 1'b0);
        chk("R5 reset data low phase", pad_dat, '0);
        rst = 1'b0;
    endtask

    task automatic test_patterns();
        send_pair(2'b00, 2'b11, 1'b1, "R3 pattern a");
        send_pair(2'b11, 2'b00, 1'b1, "R3 pattern b");
        send_pair(2'b01, 2'b10, 1'b1, "R6 lane split a");
        send_pair(2'b10, 2'b01, 1'b1, "R6 lane split b");
        send_pair(2'b10, 2'b10, 1'b1, "R1 R2 same bits");
    endtask

    task automatic test_random();
        for (int i = 0; i < 40; i++) begin
            send_pair(LANES'($urandom), LANES'($urandom), 1'b1, "R3 random stream");
        end
    endtask

    task automatic test_enable();
        send_pair(2'b11, 2'b01, 1'b0, "R4 disable period");
        send_pair(2'b01, 2'b11, 1'b1, "R4 re-enable period");
        send_pair(2'b00, 2'b00, 1'b0, "R4 disable again");
        send_pair(2'b10, 2'b11, 1'b1, "R4 enable after gap");
    endtask

    task automatic test_no_through_path();
        logic [LANES-1:0] held;
        send_pair(2'b01, 2'b10, 1'b1, "R7 setup");
        held = pad_dat;
        d_early = ~d_early;
        d_late  = ~d_late;
        #1;
        chk("R7 low phase unchanged by inputs", pad_dat, held);
        @(posedge clk);
        #(QTR);
        chk("R2 new early after edge", pad_dat, 2'b10);
        #(2*QTR);
        chk("R1 new late after edge", pad_dat, 2'b01);
    endtask

    task automatic test_mid_reset();
        d_early = '1;
        d_late  = '1;
        oe_in   = 1'b1;
        rst     = 1'b1;
        @(posedge clk);
        #(QTR);
        chk_en("R5 mid reset en", 1'b0);
        #(2*QTR);
        chk("R5 mid reset late cleared", pad_dat, '0);
        @(posedge clk);
        #(QTR);
        chk("R5 mid reset early cleared", pad_dat, '0);
        #(2*QTR);
        rst = 1'b0;
        send_pair(2'b11, 2'b10, 1'b1, "R5 resume after reset");
    endtask

    initial begin
        test_reset();
        test_patterns();
        test_random();
        test_enable();
        test_no_through_path();
        test_mid_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule